// File: doc/BRIEF.md
# External Interrupt Sense and Pending Unit

This block sits between eight active-low external interrupt pins and the arbitration stage of an interrupt controller. Each pin is brought into the clock domain through a two-flop synchronizer. It is then sensed in one of two ways, chosen per pin: as an active-low level, or as a high-to-low transition. Transitions are caught in a pending latch that software clears by writing ones. The pending state is combined with a software force bit and gated by a per-pin enable. The result is a request vector that the downstream priority logic consumes.

Pin 0 has a second destination. A select bit in the enable register sends its request to a separate machine-check line and removes it from the ordinary request vector. A disable bit in a routing register holds that line inactive. All configuration goes through a word-wide register port with combinational read data and single-cycle writes.

The reset input is asserted asynchronously. Its release is synchronized internally, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `xirq_sense_top`

## Requirements
- R1: After reset every register reads zero, every pin is in level mode, `irq_req` is all zero and `mchk_o` is low.
- R2: In level mode, the pending bit of pin n (register 0x00, bit 31−n) reads 1 while the pin is low and 0 while it is high, two clock edges after the pin changes. Writing ones to it has no effect.
- R3: The sense-control register (0x08) holds the select for pin n at bit 15−n, so pin 0 is bit 15 and pin 7 is bit 8. A 1 selects falling-edge sense and a 0 selects low-level sense.
- R4: In edge mode, a high-to-low transition sets the pending bit within three clock edges, and the bit stays set after the pin returns high. A pin that stays low, or a low-to-high transition, does not set it again.
- R5: Writing 1 to bit 31−n of the pending register clears an edge-mode latch for pin n. Bits written as 0 leave their latches unchanged.
- R6: If a detected edge and a clearing write for the same pin fall in the same cycle, the pending bit ends up set.
- R7: The enable register (0x04) holds pin n's enable at bit 31−n, where 1 passes the request and 0 blocks it. `irq_req[n]` is (pending OR force) AND enable.
- R8: The force register (0x0C) holds pin n's force at bit 31−n. A set force bit raises the request of an enabled pin whatever the pin state is.
- R9: Bit 0 of the enable register, when set, routes pin 0's gated request to `mchk_o` and holds `irq_req[0]` at 0.
- R10: Bit 0 of the routing register (0x10), when set, holds `mchk_o` low.
- R11: Bits with no function read as zero, and so does any address other than 0x00, 0x04, 0x08, 0x0C and 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_n | input | 8 | Asynchronous external interrupt pins, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_req | output | 8 | Gated request for each pin |
| mchk_o | output | 1 | Machine-check request from pin 0 when it is routed there |

## Verification
The hardest case to reach from the ports is an edge detection and a clearing write landing in the same clock cycle. The detected edge exists only in the single cycle after the second synchronizer stage changes, so it is invisible from outside. The stimulus counts edges from the falling pin: it drops the pin half a cycle before an edge, waits two rising edges, and holds the clearing write across the third. The pending bit read back afterwards then separates an edge-wins design from a clear-wins one. Edge mode is also exercised on pin 7, whose sense select sits at the far end of the reversed bit order.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int DW        = 32;
  localparam int AW        = 5;
  localparam int NPIN      = 8;
  localparam int SENSE_TOP = 15;

  localparam logic [AW-1:0] A_PEND  = 5'h00;
  localparam logic [AW-1:0] A_MASK  = 5'h04;
  localparam logic [AW-1:0] A_SENSE = 5'h08;
  localparam logic [AW-1:0] A_FORCE = 5'h0C;
  localparam logic [AW-1:0] A_ROUTE = 5'h10;

  // Bits of a per-pin word that hold a pin (bit DW-1-n for pin n)
  function automatic logic [DW-1:0] pin_field(input int npin);
    logic [DW-1:0] v;
    v = '0;
    for (int n = 0; n < npin; n++) v[DW-1-n] = 1'b1;
    return v;
  endfunction

  // Bits of the sense word that hold a pin (bit SENSE_TOP-n for pin n)
  function automatic logic [DW-1:0] sense_field(input int npin);
    logic [DW-1:0] v;
    v = '0;
    for (int n = 0; n < npin; n++) v[SENSE_TOP-n] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int   WIDTH   = 8,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= {WIDTH{RST_VAL}};
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl_n,      // synchronized pins, active low
  input  logic [NPIN-1:0] edge_mode,  // 1 = falling edge, 0 = low level
  input  logic [NPIN-1:0] clr,        // write-one-to-clear pulses
  output logic [NPIN-1:0] pend
);
  logic [NPIN-1:0] prev_q, prev_d;
  logic [NPIN-1:0] lat_q, lat_d;
  logic [NPIN-1:0] fall;

  always_comb begin
    prev_d = lvl_n;
    fall   = prev_q & ~lvl_n;
    // set beats clear; level-mode pins keep no latch
    lat_d  = edge_mode & (fall | (lat_q & ~clr));
    pend   = (edge_mode & lat_q) | (~edge_mode & ~lvl_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      lat_q  <= '0;
    end else begin
      prev_q <= prev_d;
      lat_q  <= lat_d;
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_chk
    // R4
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[n] && fall[n]) |=> pend[n] || !edge_mode[n]);
    // R6
    edge_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[n] && fall[n] && clr[n]) |=> lat_q[n]);
    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[n] && lat_q[n] && !clr[n]) |=> lat_q[n] || !edge_mode[n]);
  end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NPIN-1:0] pend,
  output logic [DW-1:0]   rdata,
  output logic [NPIN-1:0] enable,
  output logic [NPIN-1:0] edge_mode,
  output logic [NPIN-1:0] force_req,
  output logic [NPIN-1:0] clr,
  output logic            route_mchk,
  output logic            mchk_dis
);
  localparam logic [DW-1:0] PIN_BITS   = pin_field(NPIN);
  localparam logic [DW-1:0] MASK_BITS  = PIN_BITS | {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] SENSE_BITS = sense_field(NPIN);
  localparam logic [DW-1:0] ROUTE_BITS = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] mask_q, mask_d;
  logic [DW-1:0] sense_q, sense_d;
  logic [DW-1:0] force_q, force_d;
  logic [DW-1:0] route_q, route_d;
  logic          hit_pend, hit_mask, hit_sense, hit_force, hit_route;
  logic [DW-1:0] pend_word;

  always_comb begin
    hit_pend  = (addr == A_PEND);
    hit_mask  = (addr == A_MASK);
    hit_sense = (addr == A_SENSE);
    hit_force = (addr == A_FORCE);
    hit_route = (addr == A_ROUTE);
    mask_d  = (wr_en && hit_mask)  ? (wdata & MASK_BITS)  : mask_q;
    sense_d = (wr_en && hit_sense) ? (wdata & SENSE_BITS) : sense_q;
    force_d = (wr_en && hit_force) ? (wdata & PIN_BITS)   : force_q;
    route_d = (wr_en && hit_route) ? (wdata & ROUTE_BITS) : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sense_q <= '0;
      force_q <= '0;
      route_q <= '0;
    end else begin
      mask_q  <= mask_d;
      sense_q <= sense_d;
      force_q <= force_d;
      route_q <= route_d;
    end
  end

  for (genvar n = 0; n < NPIN; n++) begin : g_map
    assign enable[n]    = mask_q[DW-1-n];
    assign force_req[n] = force_q[DW-1-n];
    assign edge_mode[n] = sense_q[SENSE_TOP-n];
    assign clr[n]       = wr_en && hit_pend && wdata[DW-1-n];
  end

  always_comb begin
    pend_word = '0;
    for (int n = 0; n < NPIN; n++) pend_word[DW-1-n] = pend[n];
    unique case (1'b1)
      hit_pend:  rdata = pend_word;
      hit_mask:  rdata = mask_q;
      hit_sense: rdata = sense_q;
      hit_force: rdata = force_q;
      hit_route: rdata = route_q;
      default:   rdata = '0;
    endcase
  end

  assign route_mchk = mask_q[0];
  assign mchk_dis   = route_q[0];

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & ~MASK_BITS) == '0) && ((sense_q & ~SENSE_BITS) == '0));
endmodule

// File: rtl/xirq_sense_top.sv
module xirq_sense_top
  import xirq_pkg::*;
#(
  parameter int NPIN      = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NPIN-1:0] irq_req,
  output logic            mchk_o
);
  logic            rst_s;
  logic [NPIN-1:0] lvl_n;
  logic [NPIN-1:0] pend, enable, edge_mode, force_req, clr;
  logic            route_mchk, mchk_dis;
  logic [NPIN-1:0] gated;

  xirq_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_s));

  xirq_sync #(.WIDTH(NPIN), .STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_s), .d(pin_n), .q(lvl_n));

  xirq_sense #(.NPIN(NPIN)) u_sense (
    .clk(clk), .rst_n(rst_s), .lvl_n(lvl_n), .edge_mode(edge_mode),
    .clr(clr), .pend(pend));

  xirq_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend(pend), .rdata(rdata), .enable(enable), .edge_mode(edge_mode),
    .force_req(force_req), .clr(clr), .route_mchk(route_mchk),
    .mchk_dis(mchk_dis));

  always_comb begin
    gated      = (pend | force_req) & enable;
    irq_req    = gated;
    irq_req[0] = gated[0] & ~route_mchk;
    mchk_o     = gated[0] & route_mchk & ~mchk_dis;
  end

  // R9
  mchk_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(mchk_o && irq_req[0]));
  // R10
  mchk_dis_chk: assert property (@(posedge clk) disable iff (!rst_s)
    mchk_dis |-> !mchk_o);
  // R7
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_req & ~enable) == '0);
endmodule

// File: tb/tb_xirq_sense_top.sv
module tb_xirq_sense_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  pin_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  irq_req;
  logic        mchk_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xirq_sense_top dut (.clk(clk), .rst_n(rst_n), .pin_n(pin_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req), .mchk_o(mchk_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      chk("R1 register after reset", v, 32'h0);
    end
    chk("R1 irq_req after reset", {24'h0, irq_req}, 32'h0);
    chk("R1 mchk_o after reset", {31'h0, mchk_o}, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    @(negedge clk); pin_n[3] = 1'b0;
    wait_cyc(4);
    rd(5'h00, v); chk("R2 level low pends", v, 32'h1000_0000);
    wr(5'h00, 32'h1000_0000);
    rd(5'h00, v); chk("R2 clear ignored in level mode", v, 32'h1000_0000);
    @(negedge clk); pin_n[3] = 1'b1;
    wait_cyc(4);
    rd(5'h00, v); chk("R2 level high not pending", v, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(5'h08, 32'h0000_0400);  // pin 5 -> bit 10
    rd(5'h08, v); chk("R3 sense readback pin5", v, 32'h0000_0400);
    @(negedge clk); pin_n[5] = 1'b0;
    wait_cyc(4);
    @(negedge clk); pin_n[5] = 1'b1;
    wait_cyc(4);
    rd(5'h00, v); chk("R4 edge latched after pin high", v, 32'h0400_0000);
    wr(5'h00, 32'hFBFF_FFFF);
    rd(5'h00, v); chk("R5 zero bit leaves latch", v, 32'h0400_0000);
    wr(5'h00, 32'h0400_0000);
    rd(5'h00, v); chk("R5 one bit clears latch", v, 32'h0);
    @(negedge clk); pin_n[5] = 1'b0;
    wait_cyc(4);
    wr(5'h00, 32'h0400_0000);
    wait_cyc(4);
    rd(5'h00, v); chk("R4 held low does not re-pend", v, 32'h0);
    @(negedge clk); pin_n[5] = 1'b1;
    wait_cyc(4);
    rd(5'h00, v); chk("R4 rising edge does not pend", v, 32'h0);
    // pin 7 at bit 8 and pin 0 at bit 15
    wr(5'h08, 32'h0000_8100);
    @(negedge clk); pin_n[7] = 1'b0;
    wait_cyc(4);
    @(negedge clk); pin_n[7] = 1'b1;
    wait_cyc(4);
    rd(5'h00, v); chk("R3 pin7 edge via bit 8", v, 32'h0100_0000);
    wr(5'h00, 32'h0100_0000);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    wr(5'h08, 32'h0000_2000);  // pin 2 edge
    @(negedge clk); pin_n[2] = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b1; addr = 5'h00; wdata = 32'h2000_0000;
    @(negedge clk); wr_en = 1'b0;
    rd(5'h00, v); chk("R6 edge wins over clear", v, 32'h2000_0000);
    @(negedge clk); pin_n[2] = 1'b1;
    wait_cyc(4);
    wr(5'h00, 32'h2000_0000);
    wr(5'h08, 32'h0);
  endtask

  task automatic t_mask_force;
    @(negedge clk); pin_n[2] = 1'b0;
    wait_cyc(4);
    #1 chk("R7 blocked when enable clear", {24'h0, irq_req}, 32'h0);
    wr(5'h04, 32'h2000_0000);
    #1 chk("R7 passed when enabled", {24'h0, irq_req}, 32'h04);
    @(negedge clk); pin_n[2] = 1'b1;
    wait_cyc(4);
    wr(5'h0C, 32'h0200_0000);  // force pin 6
    #1 chk("R8 force without enable", {24'h0, irq_req}, 32'h0);
    wr(5'h04, 32'h0200_0000);
    #1 chk("R8 force with enable", {24'h0, irq_req}, 32'h40);
    wr(5'h0C, 32'h0);
    wr(5'h04, 32'h0);
  endtask

  task automatic t_mchk;
    wr(5'h0C, 32'h8000_0000);
    wr(5'h04, 32'h8000_0001);
    #1 chk("R9 routed to mchk_o", {31'h0, mchk_o}, 32'h1);
    chk("R9 irq_req0 held low", {24'h0, irq_req}, 32'h0);
    wr(5'h10, 32'h1);
    #1 chk("R10 disable holds mchk_o low", {31'h0, mchk_o}, 32'h0);
    wr(5'h04, 32'h8000_0000);
    #1 chk("R9 unrouted goes to irq_req", {24'h0, irq_req}, 32'h01);
    wr(5'h10, 32'h0); wr(5'h0C, 32'h0); wr(5'h04, 32'h0);
  endtask

  task automatic t_unused;
    logic [31:0] v;
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R11 enable unused bits", v, 32'hFF00_0001);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); chk("R11 sense unused bits", v, 32'h0000_FF00);
    wr(5'h10, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R11 routing unused bits", v, 32'h0000_0001);
    rd(5'h14, v); chk("R11 unmapped address", v, 32'h0);
    rd(5'h06, v); chk("R11 unaligned address", v, 32'h0);
    wr(5'h04, 32'h0); wr(5'h08, 32'h0); wr(5'h10, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; pin_n = 8'hFF; wr_en = 1'b0; addr = '0; wdata = '0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_level();
    t_edge();
    t_same_cycle();
    t_mask_force();
    t_mchk();
    t_unused();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule